// File: doc/BRIEF.md
# Pad Interrupt Channel Router

This block takes a wide bank of pad signals and routes a few of them onto eight interrupt channels for a downstream interrupt controller. Each channel has its own select field that names one pad. The chosen pad is synchronised to the local clock and optionally inverted. A glitch filter of programmable length follows, and the channel is then either passed through as a level or turned into a one-cycle pulse on a rising transition. Because the inversion comes before detection, active-low levels and falling edges reach the controller as active-high levels and rising edges. A channel cannot fire on both edges.

Software sets up the block through four 32-bit configuration words on a simple write port with byte enables. The read port is combinational. The number of pads that really exist is a parameter. Any select value that names a pad past that count feeds a constant 0 into the channel.

Top module: `pad_irq_router`

## Requirements
- R1: After reset, all four configuration words read 0 and `irq_out` is 0.
- R2: A write changes only the bytes whose `reg_be` bit is set. `reg_addr[3:2]` picks the word: 0 is sense/polarity, 1 is selects for channels 0-3, 2 is selects for channels 4-7, and 3 is filter lengths. In word 0, only bits 7:0 (sense) and 23:16 (invert) are stored, and every other bit reads 0.
- R3: Channel n takes its pad index from bits [(n mod 4)*8 +: 8] of word 1 when n < 4, and of word 2 otherwise.
- R4: A select value at or above `PAD_COUNT` feeds 0 into the channel. With inversion set, such a channel therefore reads asserted in level mode.
- R5: With filter length 0 in level mode, a pad change applied before clock edge k shows on `irq_out` after edge k+2 and not before. This delay comes from two synchroniser stages and one filter stage.
- R6: Setting bit 16+n of word 0 inverts channel n's pad before filtering. This turns active-low into active-high and falling into rising.
- R7: When bit n of word 0 is clear (level mode), `irq_out[n]` equals the filtered signal.
- R8: When bit n of word 0 is set (edge mode), `irq_out[n]` is high for exactly one cycle after each rising transition of the filtered signal, and never for two cycles in a row.
- R9: For a non-zero filter length N in bits [4n +: 4] of word 3, the filtered value takes a new value only after the synchronised, inverted input has differed from it for N consecutive cycles. Shorter pulses are dropped.
- R10: Filter length 0 makes the filtered value follow the synchronised, inverted input with one register of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pads | input | PAD_COUNT | Asynchronous pad signals |
| reg_wen | input | 1 | Configuration write strobe |
| reg_addr | input | 4 | Byte address; bits 3:2 pick the word |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word at `reg_addr` |
| irq_out | output | 8 | Active-high interrupt lines, one per channel |

## Verification
The bench aims at the latency of the synchroniser and filter chain. A missing or extra stage would move every assertion by a cycle. It also checks the filter boundary: a pulse one cycle shorter than the programmed length must be dropped, and a filter that counts off by one would let it through. Selects past the pad count are driven with inversion set, so a design that wraps the index would pick up a live pad instead of a constant. Edge mode is checked for a single-cycle pulse on both rising and inverted falling inputs, and a random phase with a behavioural model checks mid-stream reconfiguration and partial byte-enable writes.

// File: rtl/pad_irq_router.sv
module pad_irq_router #(
  parameter int PAD_COUNT = 133
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PAD_COUNT-1:0] pads,
  input  logic                 reg_wen,
  input  logic [3:0]           reg_addr,
  input  logic [3:0]           reg_be,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [7:0]           irq_out
);
  localparam int CH    = 8;
  localparam int SEL_W = 8;
  localparam int FLT_W = 4;
  localparam int SPAN  = 1 << SEL_W;

  logic [CH-1:0] edge_en, inv_en;
  logic [31:0]   sel_a, sel_b, flt_word, wmask;
  logic [SPAN-1:0] pad_ext;
  logic [CH-1:0] pick, s1, s2, raw, filt, prev;

  assign wmask = {{8{reg_be[3]}}, {8{reg_be[2]}}, {8{reg_be[1]}}, {8{reg_be[0]}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_en  <= '0;
      inv_en   <= '0;
      sel_a    <= '0;
      sel_b    <= '0;
      flt_word <= '0;
    end else if (reg_wen) begin
      case (reg_addr[3:2])
        2'd0: begin
          edge_en <= (edge_en & ~wmask[7:0])   | (reg_wdata[7:0]   & wmask[7:0]);
          inv_en  <= (inv_en  & ~wmask[23:16]) | (reg_wdata[23:16] & wmask[23:16]);
        end
        2'd1:    sel_a    <= (sel_a    & ~wmask) | (reg_wdata & wmask);
        2'd2:    sel_b    <= (sel_b    & ~wmask) | (reg_wdata & wmask);
        default: flt_word <= (flt_word & ~wmask) | (reg_wdata & wmask);
      endcase
    end
  end

  always_comb begin
    case (reg_addr[3:2])
      2'd0:    reg_rdata = {8'h00, inv_en, 8'h00, edge_en};
      2'd1:    reg_rdata = sel_a;
      2'd2:    reg_rdata = sel_b;
      default: reg_rdata = flt_word;
    endcase
  end

  always_comb begin
    pad_ext = '0;
    pad_ext[PAD_COUNT-1:0] = pads;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
    end else begin
      s1   <= pick;
      s2   <= s1;
      prev <= filt;
    end
  end

  assign raw = s2 ^ inv_en;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    localparam int OFS = (c % 4) * SEL_W;
    logic [SEL_W-1:0] sel;
    logic [FLT_W-1:0] flen, cnt;
    logic [FLT_W:0]   cnt_nxt;
    logic             f_q;

    assign sel     = (c < 4) ? sel_a[OFS +: SEL_W] : sel_b[OFS +: SEL_W];
    assign pick[c] = pad_ext[sel];
    assign flen    = flt_word[c*FLT_W +: FLT_W];
    assign cnt_nxt = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        f_q <= 1'b0;
      end else if (raw[c] == f_q) begin
        cnt <= '0;
      end else if (cnt_nxt >= {1'b0, flen}) begin
        f_q <= raw[c];
        cnt <= '0;
      end else begin
        cnt <= cnt_nxt[FLT_W-1:0];
      end
    end

    assign filt[c] = f_q;
  end

  assign irq_out = filt & ~(edge_en & prev);
endmodule

// File: rtl/pad_irq_router_checker.sv
module pad_irq_router_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  irq_out,
  input logic [7:0]  edge_en,
  input logic [7:0]  raw,
  input logic [7:0]  filt,
  input logic [31:0] flt_word
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_out == 8'h00); // R1

  for (genvar c = 0; c < 8; c++) begin : g_p
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_en[c] && $past(irq_out[c])) |-> !irq_out[c]); // R8

    AST_FILTER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (filt[c] != $past(filt[c])) |-> ($past(raw[c]) != $past(filt[c]))); // R9

    AST_BYPASS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_en[c] && $past(flt_word[c*4 +: 4]) == 4'd0) |-> irq_out[c] == $past(raw[c])); // R10
  end
endmodule

bind pad_irq_router pad_irq_router_checker i_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .edge_en(edge_en),
  .raw(raw), .filt(filt), .flt_word(flt_word)
);

// File: tb/test_pad_irq_router.sv
module test_pad_irq_router;
  localparam int PAD_COUNT = 133;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PAD_COUNT-1:0] pads = '0;
  logic reg_wen = 1'b0;
  logic [3:0] reg_addr = '0, reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0] irq_out;

  int n_chk = 0, n_fail = 0;
  bit model_on = 0;

  logic [7:0]  m_edge, m_inv, m_s1, m_s2, m_f, m_prev;
  logic [31:0] m_w1, m_w2, m_w3;
  int m_cnt[8];

  always #5 clk = ~clk;

  pad_irq_router #(.PAD_COUNT(PAD_COUNT)) i_pad_irq_router (
    .clk(clk), .rst_n(rst_n), .pads(pads), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a[3:2])
      2'd0:    return {8'h00, m_inv, 8'h00, m_edge};
      2'd1:    return m_w1;
      2'd2:    return m_w2;
      default: return m_w3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edge = 0; m_inv = 0; m_s1 = 0; m_s2 = 0; m_f = 0; m_prev = 0;
      m_w1 = 0; m_w2 = 0; m_w3 = 0;
      for (int c = 0; c < 8; c++) m_cnt[c] = 0;
    end else begin
      for (int c = 0; c < 8; c++) begin
        logic r;
        int sel, len;
        r = m_s2[c] ^ m_inv[c];
        len = int'(m_w3[c*4 +: 4]);
        m_prev[c] = m_f[c];
        if (r == m_f[c]) m_cnt[c] = 0;
        else if (m_cnt[c] + 1 >= len) begin m_f[c] = r; m_cnt[c] = 0; end
        else m_cnt[c] = m_cnt[c] + 1;
        m_s2[c] = m_s1[c];
        sel = (c < 4) ? int'(m_w1[(c%4)*8 +: 8]) : int'(m_w2[(c%4)*8 +: 8]);
        m_s1[c] = (sel < PAD_COUNT) ? pads[sel] : 1'b0;
      end
      if (reg_wen) begin
        logic [31:0] w0;
        case (reg_addr[3:2])
          2'd0: begin
            w0 = merge({8'h00, m_inv, 8'h00, m_edge}, reg_wdata, reg_be);
            m_edge = w0[7:0]; m_inv = w0[23:16];
          end
          2'd1: m_w1 = merge(m_w1, reg_wdata, reg_be);
          2'd2: m_w2 = merge(m_w2, reg_wdata, reg_be);
          default: m_w3 = merge(m_w3, reg_wdata, reg_be);
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      logic [7:0] e;
      for (int c = 0; c < 8; c++) e[c] = m_edge[c] ? (m_f[c] & ~m_prev[c]) : m_f[c];
      chk("R7/R8 model", {24'h0, irq_out}, {24'h0, e});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    // R1
    rd("R1 word0", 4'h0, 0); rd("R1 word1", 4'h4, 0);
    rd("R1 word2", 4'h8, 0); rd("R1 word3", 4'hC, 0);
    chk("R1 irq", {24'h0, irq_out}, 0);
    model_on = 1;

    // R2 byte enables and unused bits
    wr(4'h0, 4'b0101, 32'hFFFF_FFFF); rd("R2 be0101", 4'h0, 32'h00FF_00FF);
    wr(4'h0, 4'b1010, 32'h0000_0000); rd("R2 unused bytes", 4'h0, 32'h00FF_00FF);
    wr(4'h0, 4'b0001, 32'h0000_0000); rd("R2 be0001", 4'h0, 32'h00FF_0000);
    wr(4'h0, 4'b1111, 32'h0);         rd("R2 clear", 4'h0, 0);
    wr(4'h4, 4'b0011, 32'h1234_5678); rd("R2 partial", 4'h4, 32'h0000_5678);
    wr(4'hC, 4'b1000, 32'hABCD_EF01); rd("R2 filter word", 4'hC, 32'hAB00_0000);
    wr(4'h4, 4'hF, 0); wr(4'hC, 4'hF, 0);

    // R3 and R5: ch5 -> pad 100, ch7 -> pad 132
    wr(4'h8, 4'hF, 32'h8400_6400);
    cyc(4);
    pads[100] = 1'b1;
    cyc(2); chk("R5 not yet", {24'h0, irq_out}, 32'h00);
    cyc(1); chk("R3 R5 ch5", {24'h0, irq_out}, 32'h20);
    pads[132] = 1'b1;
    cyc(3); chk("R3 ch7", {24'h0, irq_out}, 32'hA0);
    pads = '0;
    cyc(3); chk("R7 level drop", {24'h0, irq_out}, 32'h00);

    // R4 and R6: ch6 select 200 past PAD_COUNT
    wr(4'h8, 4'hF, 32'h00C8_0000);
    pads = '1;
    cyc(4); chk("R4 out of range", {24'h0, irq_out[6]}, 0);
    wr(4'h0, 4'hF, 32'h0040_0000);
    cyc(3); chk("R4 R6 inverted const", {24'h0, irq_out[6]}, 1);
    pads = '0;
    wr(4'h0, 4'hF, 0); wr(4'h8, 4'hF, 0);
    cyc(4);

    // R8 edge mode: ch0 -> pad 5
    wr(4'h4, 4'hF, 32'h0000_0005);
    wr(4'h0, 4'hF, 32'h0000_0001);
    cyc(4);
    pads[5] = 1'b1;
    cyc(3); chk("R8 rise pulse", {24'h0, irq_out[0]}, 1);
    cyc(1); chk("R8 pulse one cycle", {24'h0, irq_out[0]}, 0);
    wr(4'h0, 4'hF, 32'h0001_0001);
    cyc(5);
    pads[5] = 1'b0;
    cyc(3); chk("R6 R8 falling pulse", {24'h0, irq_out[0]}, 1);
    cyc(1); chk("R8 falling one cycle", {24'h0, irq_out[0]}, 0);
    wr(4'h0, 4'hF, 0);
    cyc(4);

    // R9 filter: ch2 -> pad 10, length 4
    wr(4'h4, 4'hF, 32'h000A_0000);
    wr(4'hC, 4'hF, 32'h0000_0400);
    cyc(6);
    pads[10] = 1'b1; cyc(3); pads[10] = 1'b0;
    begin
      logic seen = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); seen |= irq_out[2]; end
      chk("R9 short pulse dropped", {31'h0, seen}, 0);
    end
    pads[10] = 1'b1;
    cyc(5); chk("R9 before length", {24'h0, irq_out[2]}, 0);
    cyc(1); chk("R9 after length", {24'h0, irq_out[2]}, 1);
    pads[10] = 1'b0;
    cyc(6); chk("R9 release", {24'h0, irq_out[2]}, 0);

    // R10: length 0 on the same channel
    wr(4'hC, 4'hF, 0);
    pads[10] = 1'b1;
    cyc(3); chk("R10 bypass", {24'h0, irq_out[2]}, 1);
    pads = '0;
    cyc(4);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (i % 3 == 0)
        for (int p = 0; p < PAD_COUNT; p++) if ($urandom % 4 == 0) pads[p] = ~pads[p];
      reg_wen   = ($urandom % 25 == 0);
      reg_addr  = 4'($urandom % 4) << 2;
      reg_be    = 4'($urandom);
      reg_wdata = $urandom;
      if (reg_addr == 4'h4 || reg_addr == 4'h8)
        reg_wdata = reg_wdata & 32'h9F9F_9F9F;
      if (i % 50 == 49) begin
        reg_wen = 1'b0;
        #1;
        chk("R2 model read", reg_rdata, model_read(reg_addr));
      end
    end
    reg_wen = 1'b0;
    cyc(4);
    finish_run();
  end
endmodule